// File: doc/BRIEF.md
# Flash Register Reset and Recovery Sequencer

This block controls reset and reset recovery for the register interface of a flash controller. An active-low reset request takes effect at once and outranks everything else. It clears the control word, which stops any program or erase operation in progress and removes the high-voltage enable. It also pulls the `ready_done` status low. After reset is released, the block waits a fixed number of recovery cycles. It then asks the shadow storage for configuration data through a request/acknowledge handshake. Once the data is captured, it raises `ready_done` and enters user mode.

A four-state machine drives the sequence:
- `ST_RESET` is held while reset is asserted. On the first clock after release it always moves to `ST_RECOVER`.
- `ST_RECOVER` counts `REC_CYCLES` cycles and then moves to `ST_SHADOW`.
- `ST_SHADOW` holds `shd_req` high. It moves to `ST_READY` on the clock where `shd_ack` is high.
- `ST_READY` is left only by reset.

Register reads are served in every state. The shadow-loaded word is marked stale until `ready_done` rises. Writes that arrive before then are dropped and set a sticky error bit. Software clears that bit by writing 1 to it.

Register map (`AW`-bit word address): 0 = control word, 1 = status, 2 = shadow configuration (read-only). Any other address reads 0.
- Control word: bit 0 = program, bit 1 = erase, bit 2 = high-voltage arm. The remaining bits are stored as plain read/write bits.
- Status: bit 0 = done (read-only), bit 1 = write error (write 1 to clear).

Top module: `flash_rst_seq`

## Requirements
- R1: While `rst_n` is low, `hv_en` is 0, `ready_done` is 0, `wr_err` is 0, and the control word (address 0) reads 0, without waiting for a clock edge.
- R2: After reset is released, `shd_req` is 0 for the first `REC_CYCLES`+1 clock edges. It is 1 after edge `REC_CYCLES`+1, and `ready_done` stays 0 throughout this period.
- R3: Once `shd_req` is high, it stays high until a clock edge samples `shd_ack` high. On that edge `shd_data` is captured into the shadow word (address 2), and `shd_req` then drops.
- R4: `ready_done` goes from 0 to 1 only on the edge after a cycle in which `shd_req` and `shd_ack` were both high. After that it stays 1 until the next reset.
- R5: A write (`reg_wr` high at a clock edge) while `ready_done` is 0 changes neither the control word nor the status error bit clearing.
- R6: A write ignored under R5 sets `wr_err` (status bit 1), and the bit stays set.
- R7: With `ready_done` at 1, a write to address 1 with bit 1 set clears `wr_err` on the next cycle. A write with bit 1 clear leaves it unchanged.
- R8: `reg_stale` is 1 when address 2 is selected and `ready_done` is 0. In every other case it is 0.
- R9: With `ready_done` at 1, a write to address 0 loads the whole control word on the next cycle. `hv_en` then equals arm AND (program OR erase).
- R10: Reads are combinational. Address 0 returns the control word, address 1 returns {error, done} in bits [1:0], address 2 returns the shadow word, and other addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr` |
| reg_stale | output | 1 | Selected field is not yet reloaded from shadow |
| shd_req | output | 1 | Shadow load request |
| shd_ack | input | 1 | Shadow data valid / acknowledge |
| shd_data | input | DW | Shadow configuration data |
| hv_en | output | 1 | High-voltage enable to the analog block |
| ready_done | output | 1 | Reset recovery complete, user mode |
| wr_err | output | 1 | Sticky ignored-write error |

## Verification
The bench places reset in the middle of an armed program operation and checks that high voltage drops in the same moment. A design that waited for a clock edge would leave the pump running for a cycle. It counts edges from reset release to the shadow request, so a counter that is off by one in either direction shows up. It holds `shd_ack` low for random spans to catch a design that raises done without the handshake. It writes during the reset, recovery and shadow phases, which exposes a design that lets early writes reach the control word or fails to flag them. Random traffic in user mode then checks write-1-to-clear of the error bit, the high-voltage decode, stale flagging and the read map against a bench model.

// File: rtl/flash_rst_pkg.sv
package flash_rst_pkg;

    typedef enum logic [1:0] {
        ST_RESET   = 2'd0,
        ST_RECOVER = 2'd1,
        ST_SHADOW  = 2'd2,
        ST_READY   = 2'd3
    } rec_state_t;

    // register word addresses
    localparam int ADR_CTRL = 0;
    localparam int ADR_STAT = 1;
    localparam int ADR_SHDW = 2;

    // control word bit positions
    localparam int CTL_PGM = 0;
    localparam int CTL_ERS = 1;
    localparam int CTL_HV  = 2;

    // status word bit positions
    localparam int STS_DONE = 0;
    localparam int STS_ERR  = 1;

endpackage

// File: rtl/flash_rst_fsm.sv
module flash_rst_fsm
    import flash_rst_pkg::*;
#(
    parameter int REC_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shd_ack,
    output logic shd_req,
    output logic load_shadow,
    output logic done
);

    localparam int CW = $clog2(REC_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(REC_CYCLES - 1);

    rec_state_t     state_q, state_d;
    logic [CW-1:0]  cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    // recovery counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (state_q == ST_RECOVER)  cnt_q <= cnt_q + 1'b1;
        else                             cnt_q <= '0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:   state_d = ST_RECOVER;
            ST_RECOVER: if (cnt_q == CNT_LAST) state_d = ST_SHADOW;
            ST_SHADOW:  if (shd_ack) state_d = ST_READY;
            ST_READY:   state_d = ST_READY;
            default:    state_d = ST_RESET;
        endcase
    end

    // outputs
    always_comb begin
        shd_req     = 1'b0;
        load_shadow = 1'b0;
        done        = 1'b0;
        unique case (state_q)
            ST_RESET, ST_RECOVER: ;
            ST_SHADOW: begin
                shd_req     = 1'b1;
                load_shadow = shd_ack;
            end
            ST_READY:  done = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/flash_rst_regs.sv
module flash_rst_regs
    import flash_rst_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    input  logic [DW-1:0] shd_data,
    output logic [DW-1:0] rdata,
    output logic          stale,
    output logic          hv_en,
    output logic          err,
    output logic [DW-1:0] ctrl
);

    localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);
    localparam logic [AW-1:0] A_STAT = AW'(ADR_STAT);
    localparam logic [AW-1:0] A_SHDW = AW'(ADR_SHDW);

    logic [DW-1:0] ctrl_q, shdw_q;
    logic          err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            shdw_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (load) shdw_q <= shd_data;
            if (wr) begin
                if (!done) begin
                    err_q <= 1'b1;
                end else if (addr == A_CTRL) begin
                    ctrl_q <= wdata;
                end else if (addr == A_STAT && wdata[STS_ERR]) begin
                    err_q <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = ctrl_q;
        end else if (addr == A_STAT) begin
            rdata[STS_DONE] = done;
            rdata[STS_ERR]  = err_q;
        end else if (addr == A_SHDW) begin
            rdata = shdw_q;
        end
    end

    assign stale = (addr == A_SHDW) && !done;
    assign hv_en = ctrl_q[CTL_HV] & (ctrl_q[CTL_PGM] | ctrl_q[CTL_ERS]);
    assign err   = err_q;
    assign ctrl  = ctrl_q;

endmodule

// File: rtl/flash_rst_seq.sv
module flash_rst_seq #(
    parameter int DW         = 16,
    parameter int AW         = 2,
    parameter int REC_CYCLES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          reg_stale,
    output logic          shd_req,
    input  logic          shd_ack,
    input  logic [DW-1:0] shd_data,
    output logic          hv_en,
    output logic          ready_done,
    output logic          wr_err
);

    logic          load_shadow;
    logic [DW-1:0] ctrl_word;

    flash_rst_fsm #(
        .REC_CYCLES (REC_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .shd_ack     (shd_ack),
        .shd_req     (shd_req),
        .load_shadow (load_shadow),
        .done        (ready_done)
    );

    flash_rst_regs #(
        .DW (DW),
        .AW (AW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (ready_done),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .load     (load_shadow),
        .shd_data (shd_data),
        .rdata    (reg_rdata),
        .stale    (reg_stale),
        .hv_en    (hv_en),
        .err      (wr_err),
        .ctrl     (ctrl_word)
    );

endmodule

// File: rtl/flash_rst_chk.sv
module flash_rst_chk #(
    parameter int DW         = 16,
    parameter int AW         = 2,
    parameter int REC_CYCLES = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic          reg_stale,
    input logic          shd_req,
    input logic          shd_ack,
    input logic          hv_en,
    input logic          ready_done,
    input logic          wr_err,
    input logic [DW-1:0] ctrl_word
);

    localparam int SW = $clog2(REC_CYCLES + 2) + 1;
    localparam logic [SW-1:0] SAT = SW'(REC_CYCLES + 1);

    logic [SW-1:0] since_rel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rel <= '0;
        else if (since_rel < SAT) since_rel <= since_rel + 1'b1;
    end

    // R1
    hv_off_in_reset_chk: assert property (@(posedge clk)
        !rst_n |-> (!hv_en && !ready_done && !wr_err));

    // R2
    early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_done |-> (since_rel >= SAT));

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shd_req && !shd_ack) |=> shd_req);

    // R4
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_done) |-> $past(shd_req && shd_ack));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready_done |=> ready_done);

    // R5
    early_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ready_done) |=> $stable(ctrl_word));

    // R6
    early_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ready_done) |=> wr_err);

    // R8
    stale_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(2) && !ready_done) |-> reg_stale);

endmodule

bind flash_rst_seq flash_rst_chk #(
    .DW         (DW),
    .AW         (AW),
    .REC_CYCLES (REC_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_stale  (reg_stale),
    .shd_req    (shd_req),
    .shd_ack    (shd_ack),
    .hv_en      (hv_en),
    .ready_done (ready_done),
    .wr_err     (wr_err),
    .ctrl_word  (ctrl_word)
);

// File: tb/tb_flash_rst_seq.sv
`timescale 1ns/1ps
module tb_flash_rst_seq;

    localparam int DW  = 16;
    localparam int AW  = 2;
    localparam int REC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          reg_stale;
    logic          shd_req;
    logic          shd_ack = 1'b0;
    logic [DW-1:0] shd_data = '0;
    logic          hv_en;
    logic          ready_done;
    logic          wr_err;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_ctrl;
    logic [DW-1:0] m_shdw;
    logic          m_err;
    logic          m_done;

    always #2.5 clk = ~clk;

    flash_rst_seq #(.DW(DW), .AW(AW), .REC_CYCLES(REC)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_stale(reg_stale),
        .shd_req(shd_req), .shd_ack(shd_ack), .shd_data(shd_data),
        .hv_en(hv_en), .ready_done(ready_done), .wr_err(wr_err)
    );

    function automatic logic exp_hv(input logic [DW-1:0] c);
        return c[2] & (c[0] | c[1]);
    endfunction

    function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
        logic [DW-1:0] r;
        r = '0;
        case (a)
            2'd0: r = m_ctrl;
            2'd1: begin r[0] = m_done; r[1] = m_err; end
            2'd2: r = m_shdw;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a);
        reg_addr = a;
        #0.5;
        chk({req, " rdata"}, reg_rdata, exp_rd(a));
        chk("R8 stale", DW'(reg_stale), DW'(a == 2'd2 && !m_done));
    endtask

    task automatic wr_op(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (!m_done) m_err = 1'b1;
        else if (a == 2'd0) m_ctrl = d;
        else if (a == 2'd1 && d[1]) m_err = 1'b0;
    endtask

    task automatic apply_reset();
        #0.5;
        rst_n = 1'b0;
        #0.5;
        m_ctrl = '0; m_shdw = '0; m_err = 1'b0; m_done = 1'b0;
        // R1 immediate effect, no clock edge yet
        chk("R1 hv_en", DW'(hv_en), '0);
        chk("R1 done", DW'(ready_done), '0);
        chk("R1 wr_err", DW'(wr_err), '0);
        rd_check("R1 ctrl", 2'd0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic recover(input int ack_delay, input bit early_wr);
        for (int k = 0; k <= REC; k++) begin
            chk("R2 req low", DW'(shd_req), '0);
            chk("R2 done low", DW'(ready_done), '0);
            if (early_wr && k == 2) begin
                wr_op(2'd0, 16'h0007);
                // R5 ctrl untouched, R6 error raised
                rd_check("R5 ctrl", 2'd0);
                chk("R6 err", DW'(wr_err), 1);
                k++;
                chk("R2 req low", DW'(shd_req), '0);
            end
            @(negedge clk);
        end
        chk("R2 req high", DW'(shd_req), 1);
        rd_check("R8 shadow stale", 2'd2);
        for (int d = 0; d < ack_delay; d++) begin
            @(negedge clk);
            chk("R3 req held", DW'(shd_req), 1);
            chk("R4 done low", DW'(ready_done), '0);
        end
        if (early_wr) begin
            wr_op(2'd1, 16'h0002);
            chk("R5 err not cleared early", DW'(wr_err), 1);
            chk("R3 req held", DW'(shd_req), 1);
        end
        shd_data = DW'($urandom);
        shd_ack = 1'b1;
        @(negedge clk);
        shd_ack = 1'b0;
        m_shdw = shd_data;
        m_done = 1'b1;
        chk("R4 done high", DW'(ready_done), 1);
        chk("R3 req dropped", DW'(shd_req), '0);
        rd_check("R3 shadow", 2'd2);
        rd_check("R10 status", 2'd1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        m_ctrl = '0; m_shdw = '0; m_err = 1'b0; m_done = 1'b0;
        #1;
        rd_check("R1 ctrl at start", 2'd0);
        chk("R1 hv_en at start", DW'(hv_en), '0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        recover(0, 1'b0);

        for (int round = 0; round < 4; round++) begin
            // R9 arm a program operation
            wr_op(2'd0, 16'h0005);
            chk("R9 hv on", DW'(hv_en), 1);
            rd_check("R9 ctrl", 2'd0);
            // R7 clear after a leftover error
            if (m_err) begin
                wr_op(2'd1, 16'h0001);
                chk("R7 w0 keeps err", DW'(wr_err), 1);
                wr_op(2'd1, 16'h0002);
                chk("R7 w1 clears err", DW'(wr_err), 0);
            end
            for (int i = 0; i < 60; i++) begin
                logic [AW-1:0] a;
                a = AW'($urandom);
                if ($urandom % 2 == 0) wr_op(a, DW'($urandom));
                else @(negedge clk);
                rd_check("R10 random", AW'($urandom));
                chk("R9 hv decode", DW'(hv_en), DW'(exp_hv(m_ctrl)));
                chk("R7 err model", DW'(wr_err), DW'(m_err));
                chk("R4 done stays", DW'(ready_done), 1);
            end
            wr_op(2'd0, 16'h0006);
            chk("R9 erase hv on", DW'(hv_en), 1);
            // R1 reset in the middle of an armed erase
            apply_reset();
            recover(int'($urandom % 6), round != 3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule